// File: doc/BRIEF.md
# Parallel Polynomial Spline Generator

This block produces a piecewise cubic waveform for a sample path that carries several samples per coarse clock cycle. A waveform segment is described by four coefficients: a start value, a per-cycle step, a step-of-step, and a third-order step. Software-side logic packs those coefficients into one wide event word and presents it with a single-cycle strobe. The block loads all coefficients at once. From then on, on every coarse cycle, it advances the polynomial by forward differencing. The current value is driven identically onto every parallel output lane.

Coefficients of higher order carry more fractional resolution. Order `i` is stored in a field `VAL_W + i*TIME_W` bits wide. The fields are laid end to end, lowest order in the least significant bits, and the whole set is split into 32-bit words, with word 0 holding the least significant bits. An event that only fills the low fields leaves the upper fields zero, so those terms are cleared. Every event completes in the cycle it is strobed, so the busy flag never rises.

Top module: `poly_spline_gen`

## Requirements
- R1: While `rst` is high on a clock edge, every accumulator clears. From the next cycle all lanes read 0 until an event loads new coefficients, including when reset is asserted in the middle of a ramp.
- R2: `evt_busy` reads 0 at all times, including before every strobe.
- R3: With defaults (VAL_W=16, TIME_W=16), the coefficient fields sit in `evt_data` as follows:
  - order 0 is an integer in bits [15:0];
  - order 1 is an integer in bits [47:16];
  - order 2 is in bits [95:48], with its low 16 bits fractional;
  - order 3 is in bits [159:96], with its low 32 bits fractional.
  Bits [31:0] form data word 0.
- R4: When `evt_stb` is high on a clock edge, all coefficients load together. The order-0 value appears on the lanes in the cycle right after that edge, which is a latency of `OUT_LATENCY` = 1.
- R5: On each edge without a strobe, the order-0 value increases by the low VAL_W bits of the order-1 accumulator. Loading order 0 = 100 and order 1 = 10 gives 100, 110, 120, ... .
- R6: On each edge without a strobe, each middle-order accumulator adds the next higher accumulator shifted right by TIME_W bits, using values from before the edge. With integer coefficients this gives y(n) = x0 + n·s + c·n(n−1)/2 + j·n(n−1)(n−2)/6.
- R7: The lane value wraps in two's complement at VAL_W bits, with no saturation. For example, 32760 stepping by 5 gives 0x8002 after two steps.
- R8: An event that carries only an order-0 value sets the lanes to that value, and the value stays constant. Any ramp in progress stops.
- R9: All LANES output lanes carry the same value in every cycle. Lane k occupies `lane_out[k*VAL_W +: VAL_W]`.
- R10: The highest-order accumulator changes only on a strobe or a reset.
- R11: A strobe during a running ramp replaces all coefficients in that cycle, and the load takes priority over the advance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Coarse clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_stb | input | 1 | One-cycle strobe that loads a coefficient event |
| evt_data | input | 32*ceil(TOTAL/32) (160) | Packed coefficient fields, word 0 least significant |
| evt_busy | output | 1 | Busy flag, always low |
| lane_out | output | LANES*VAL_W (64) | Current value replicated onto all lanes |

## Verification
The value loaded by a strobe is due one clock edge later, because the accumulator register drives the lanes directly. Each later polynomial step is due one edge after the previous one. The bench drives the strobe on a falling edge and drops it on the next falling edge. It then compares all lanes against the closed-form sum for step n, sampled at the n-th following falling edge. Reset clearing is checked at the falling edge after the first reset edge, and the busy flag is sampled just before every strobe is raised.

// File: rtl/spline_pkg.sv
package spline_pkg;

    localparam int WORD_W      = 32;
    localparam int OUT_LATENCY = 1;

    typedef enum logic [0:0] {
        ACT_ADVANCE = 1'b0,
        ACT_LOAD    = 1'b1
    } acc_act_e;

    // width of the field holding the coefficient of order i
    function automatic int fld_w(input int w, input int t, input int i);
        return w + i * t;
    endfunction

    // bit offset of the coefficient of order i inside the packed event
    function automatic int fld_off(input int w, input int t, input int i);
        return i * w + t * ((i * (i - 1)) / 2);
    endfunction

    function automatic int pack_bits(input int w, input int t, input int n);
        return fld_off(w, t, n);
    endfunction

    function automatic int pack_words(input int w, input int t, input int n);
        return (pack_bits(w, t, n) + WORD_W - 1) / WORD_W;
    endfunction

endpackage

// File: rtl/spline_diff_stage.sv
module spline_diff_stage
    import spline_pkg::*;
#(
    parameter int FW = 16
) (
    input  acc_act_e          act,
    input  logic [FW-1:0]     cur,
    input  logic [FW-1:0]     inc,
    input  logic [FW-1:0]     coef,
    output logic [FW-1:0]     nxt
);

    always_comb begin
        if (act == ACT_LOAD) nxt = coef;
        else                 nxt = cur + inc;   // wraps modulo 2^FW
    end

endmodule

// File: rtl/spline_acc_bank.sv
module spline_acc_bank
    import spline_pkg::*;
#(
    parameter int VAL_W  = 16,
    parameter int TIME_W = 16,
    parameter int ORDERS = 4,
    localparam int TOTAL = pack_bits(VAL_W, TIME_W, ORDERS)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               load,
    input  logic [TOTAL-1:0]   coef,
    output logic [VAL_W-1:0]   value
);

    localparam int TOP_OFF = fld_off(VAL_W, TIME_W, ORDERS - 1);
    localparam int TOP_W   = fld_w(VAL_W, TIME_W, ORDERS - 1);

    logic [TOTAL-1:0] acc_q;
    logic [TOTAL-1:0] acc_d;
    acc_act_e         act;

    assign act = load ? ACT_LOAD : ACT_ADVANCE;

    for (genvar i = 0; i < ORDERS; i++) begin : g_ord
        localparam int OFF = fld_off(VAL_W, TIME_W, i);
        localparam int FW  = fld_w(VAL_W, TIME_W, i);
        if (i == ORDERS - 1) begin : g_top
            assign acc_d[OFF +: FW] = (act == ACT_LOAD) ? coef[OFF +: FW] : acc_q[OFF +: FW];
        end else begin : g_mid
            localparam int NOFF = fld_off(VAL_W, TIME_W, i + 1);
            localparam int SH   = (i == 0) ? 0 : TIME_W;
            spline_diff_stage #(.FW(FW)) stage_i (
                .act  (act),
                .cur  (acc_q[OFF +: FW]),
                .inc  (acc_q[NOFF + SH +: FW]),
                .coef (coef[OFF +: FW]),
                .nxt  (acc_d[OFF +: FW])
            );
        end
    end

    always_ff @(posedge clk) begin
        if (rst) acc_q <= '0;
        else     acc_q <= acc_d;
    end

    assign value = acc_q[VAL_W-1:0];

    assert_reset_clear_R1: assert property (@(posedge clk)
        rst |=> (acc_q == '0));

    assert_load_all_R4: assert property (@(posedge clk) disable iff (rst)
        load |=> (acc_q == $past(coef)));

    assert_top_hold_R10: assert property (@(posedge clk) disable iff (rst)
        !load |=> $stable(acc_q[TOP_OFF +: TOP_W]));

    assert_flat_hold_R8: assert property (@(posedge clk) disable iff (rst)
        (!load && (acc_q[TOTAL-1:VAL_W] == '0)) |=> $stable(acc_q[VAL_W-1:0]));

endmodule

// File: rtl/spline_lane_fanout.sv
module spline_lane_fanout #(
    parameter int VAL_W = 16,
    parameter int LANES = 4
) (
    input  logic [VAL_W-1:0]       val,
    output logic [LANES*VAL_W-1:0] lanes
);

    for (genvar k = 0; k < LANES; k++) begin : g_lane
        assign lanes[k*VAL_W +: VAL_W] = val;
    end

endmodule

// File: rtl/poly_spline_gen.sv
module poly_spline_gen
    import spline_pkg::*;
#(
    parameter int VAL_W  = 16,
    parameter int TIME_W = 16,
    parameter int ORDERS = 4,
    parameter int LANES  = 4,
    localparam int TOTAL  = pack_bits(VAL_W, TIME_W, ORDERS),
    localparam int DATA_W = WORD_W * pack_words(VAL_W, TIME_W, ORDERS)
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   evt_stb,
    input  logic [DATA_W-1:0]      evt_data,
    output logic                   evt_busy,
    output logic [LANES*VAL_W-1:0] lane_out
);

    logic [VAL_W-1:0] cur_val;

    // every event is absorbed in its own cycle
    assign evt_busy = 1'b0;

    spline_acc_bank #(
        .VAL_W  (VAL_W),
        .TIME_W (TIME_W),
        .ORDERS (ORDERS)
    ) bank_i (
        .clk   (clk),
        .rst   (rst),
        .load  (evt_stb),
        .coef  (evt_data[TOTAL-1:0]),
        .value (cur_val)
    );

    spline_lane_fanout #(
        .VAL_W (VAL_W),
        .LANES (LANES)
    ) fan_i (
        .val   (cur_val),
        .lanes (lane_out)
    );

    assert_load_visible_R4: assert property (@(posedge clk) disable iff (rst)
        evt_stb |=> (lane_out[VAL_W-1:0] == $past(evt_data[VAL_W-1:0])));

    for (genvar k = 1; k < LANES; k++) begin : g_chk
        assert_lanes_equal_R9: assert property (@(posedge clk) disable iff (rst)
            lane_out[k*VAL_W +: VAL_W] == lane_out[VAL_W-1:0]);
    end

endmodule

// File: tb/poly_spline_gen_tb_top.sv
module poly_spline_gen_tb_top;

    localparam int W     = 16;
    localparam int LANES = 4;
    localparam int DW    = 160;

    logic                 clk = 1'b0;
    logic                 rst = 1'b1;
    logic                 evt_stb = 1'b0;
    logic [DW-1:0]        evt_data = '0;
    logic                 evt_busy;
    logic [LANES*W-1:0]   lane_out;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    poly_spline_gen dut_i (
        .clk      (clk),
        .rst      (rst),
        .evt_stb  (evt_stb),
        .evt_data (evt_data),
        .evt_busy (evt_busy),
        .lane_out (lane_out)
    );

    typedef struct packed {
        longint x0;
        longint s;
        longint c;
        longint j;
        int     n;
    } vec_t;

    // start value, step, step-of-step, third-order step, cycles to follow
    localparam vec_t VECS [6] = '{
        '{100,    10,  0, 0, 10},   // R5 linear ramp
        '{0,      0,   0, 0, 3},
        '{-5,     3,   2, 0, 8},    // R6 quadratic
        '{7,      -1,  0, 1, 8},    // R6 cubic
        '{32760,  5,   0, 0, 4},    // R7 wrap
        '{1234,   0,  -3, 2, 9}     // R6 mixed signs
    };

    function automatic logic [DW-1:0] pack(input longint x0, input longint s,
                                           input longint c, input longint j);
        logic [DW-1:0] d = '0;
        longint tmp;
        d[15:0]  = x0[15:0];
        d[47:16] = s[31:0];
        tmp = c <<< 16;
        d[95:48] = tmp[47:0];
        tmp = j <<< 32;
        d[159:96] = tmp;
        return d;
    endfunction

    function automatic logic [15:0] expv(input longint x0, input longint s,
                                         input longint c, input longint j, input int n);
        longint nn = n;
        longint v;
        v = x0 + nn * s + c * ((nn * (nn - 1)) / 2) + j * ((nn * (nn - 1) * (nn - 2)) / 6);
        return v[15:0];
    endfunction

    task automatic check_lanes(input logic [15:0] exp, input string req);
        for (int k = 0; k < LANES; k++) begin
            checks++;
            if (lane_out[k*W +: W] !== exp) begin
                errors++;
                $display("FAIL %s lane %0d actual=%0h expected=%0h",
                         req, k, lane_out[k*W +: W], exp);
            end
        end
    endtask

    task automatic send(input logic [DW-1:0] d);
        @(negedge clk);
        checks++;
        if (evt_busy !== 1'b0) begin
            errors++;
            $display("FAIL R2 busy before strobe actual=%b expected=0", evt_busy);
        end
        evt_stb  = 1'b1;
        evt_data = d;
        @(negedge clk);
        evt_stb  = 1'b0;
        evt_data = '0;
    endtask

    task automatic run_vec(input vec_t v, input string req);
        send(pack(v.x0, v.s, v.c, v.j));
        check_lanes(expv(v.x0, v.s, v.c, v.j, 0), "R4");
        for (int n = 1; n <= v.n; n++) begin
            @(negedge clk);
            check_lanes(expv(v.x0, v.s, v.c, v.j, n), req);
        end
    endtask

    initial begin
        logic [DW-1:0] d;

        // reset state
        repeat (3) @(negedge clk);
        check_lanes(16'h0, "R1");
        checks++;
        if (evt_busy !== 1'b0) begin
            errors++;
            $display("FAIL R2 busy in reset actual=%b expected=0", evt_busy);
        end
        rst = 1'b0;
        @(negedge clk);
        check_lanes(16'h0, "R1");

        // R3: hand-built words, word 0 carries start 100 and step 10
        d = '0;
        d[31:0] = 32'h000A_0064;
        send(d);
        check_lanes(16'd100, "R3");
        @(negedge clk); check_lanes(16'd110, "R3");
        @(negedge clk); check_lanes(16'd120, "R3");

        // R3: integer step-of-step 1 lands on bit 64 (word 2 bit 0)
        d = '0;
        d[64] = 1'b1;
        send(d);
        check_lanes(16'd0, "R3");
        @(negedge clk); check_lanes(16'd0, "R3");
        @(negedge clk); check_lanes(16'd1, "R3");
        @(negedge clk); check_lanes(16'd3, "R3");
        @(negedge clk); check_lanes(16'd6, "R3");

        // R3: integer third-order step 1 lands on bit 128 (word 4 bit 0)
        d = '0;
        d[128] = 1'b1;
        send(d);
        check_lanes(16'd0, "R3");
        @(negedge clk); check_lanes(16'd0, "R3");
        @(negedge clk); check_lanes(16'd0, "R3");
        @(negedge clk); check_lanes(16'd1, "R3");
        @(negedge clk); check_lanes(16'd4, "R3");

        // table walk
        for (int i = 0; i < 6; i++) begin
            run_vec(VECS[i], (i == 4) ? "R7" : ((i < 2) ? "R5" : "R6"));
        end

        // R8: constant-only event stops a running ramp
        send(pack(100, 10, 0, 0));
        @(negedge clk);
        @(negedge clk);
        check_lanes(16'd120, "R5");
        send(pack(7, 0, 0, 0));
        check_lanes(16'd7, "R8");
        for (int n = 0; n < 5; n++) begin
            @(negedge clk);
            check_lanes(16'd7, "R8");
        end

        // R11: strobe during a ramp replaces it
        send(pack(50, -2, 1, 0));
        @(negedge clk);
        send(pack(1000, 1, 0, 0));
        check_lanes(16'd1000, "R11");
        @(negedge clk); check_lanes(16'd1001, "R11");
        @(negedge clk); check_lanes(16'd1002, "R11");

        // R1: reset in the middle of a cubic ramp
        send(pack(9, 4, 3, 2));
        @(negedge clk);
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        check_lanes(16'd0, "R1");
        rst = 1'b0;
        for (int n = 0; n < 3; n++) begin
            @(negedge clk);
            check_lanes(16'd0, "R1");
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL R2 watchdog actual=running expected=done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule